// File: doc/BRIEF.md
# Mailbox Access Window Generator

This block decides when a second controller may use a shared mailbox memory. It watches a reference clock line. A fixed number of timebase ticks after a rising edge on that line, it pulls an active-low grant line low. The grant line also serves as a communications interrupt request to the other controller. The other controller may access the mailbox only while the grant is low. The block holds that window open until the controller signals it is finished, or until a hard limit on the window length is reached, whichever comes first.

While the window is open, the block passes the controller's four memory strobes through and enables their drivers. At all other times the strobe drivers are disabled, so the strobes are in high impedance. A status output tells whether the last window closed because the length limit cut it short.

The window behaves as a one-shot. Reference edges that arrive while a window is pending or open are ignored, and so are release requests that arrive outside an open window. Both the delay and the limit are parameters counted in ticks. The defaults are 45 and 50, which with a 1 ms tick gives 45 ms and 50 ms.

Top module: `mbx_window_gen`

## Requirements
- R1: While rst_ni is low, grant_no is 1, strb_en_o is 0, strb_oe_o is all zeros and cut_o is 0.
- R2: A rising edge on ref_i passes through a two-flop synchronizer and starts the delay count. grant_no falls on the clock edge that samples the DELAY_TICKS-th tick_i pulse counted after that edge. A tick_i pulse is high for one clock cycle.
- R3: Once low, grant_no returns high on the clock edge that samples rel_i high. If that has not happened first, it returns high on the clock edge that samples the MAX_TICKS-th tick_i pulse counted after the fall. The window never lasts longer than MAX_TICKS ticks.
- R4: cut_o becomes 1 when a window is closed by the MAX_TICKS limit. It becomes 0 when a window is closed by rel_i. It keeps its value until the next window opens, and it is 0 while a window is open.
- R5: Rising edges on ref_i while the delay is running or the window is open are ignored: they produce no second window and do not restart the delay.
- R6: rel_i has no effect while no window is open. A rel_i pulse during the delay neither cancels nor shortens the next window.
- R7: strb_en_o is 1 and every bit of strb_oe_o is 1 exactly while grant_no is 0. At all other times they are 0.
- R8: While the window is open, each strb_o[i] equals strb_i[i]. Outside the window, every strb_o[i] is held at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_i | input | 1 | System clock reference line, asynchronous |
| tick_i | input | 1 | Timebase tick, one-cycle pulse |
| rel_i | input | 1 | Controller done; closes an open window |
| strb_i | input | NUM_STB | Strobes from the other controller |
| grant_no | output | 1 | Access grant / interrupt request, active low |
| strb_en_o | output | 1 | Strobe enable, high inside the window |
| strb_oe_o | output | NUM_STB | Per-strobe output-driver enables |
| strb_o | output | NUM_STB | Gated strobe values |
| cut_o | output | 1 | Last window was closed by the length limit |

## Verification
A stuck or wrongly loaded tick counter shows up at the next grant transition as a wrong number of ticks: the grant falls at the wrong time, or the window closes at the wrong time. So each such fault is caught within one window, at most DELAY_TICKS plus MAX_TICKS ticks after the reference edge. A state register that accepts a reference edge or a release at the wrong moment shows up as an extra window, a restarted delay or a window that closes early. A wrong strobe gate shows up on the very cycle the grant changes, or on any cycle in which strb_i differs from the value held while disabled.

// File: rtl/mbx_win_pkg.sv
package mbx_win_pkg;
  typedef enum logic [1:0] {
    WIN_IDLE  = 2'd0,
    WIN_DELAY = 2'd1,
    WIN_OPEN  = 2'd2
  } win_state_e;

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/mbx_ref_sync.sv
module mbx_ref_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], async_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

  // R2
  rise_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/mbx_tick_cnt.sv
module mbx_tick_cnt #(
  parameter int unsigned CW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [CW-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + CW'(1);
  end
endmodule

// File: rtl/mbx_win_fsm.sv
module mbx_win_fsm
  import mbx_win_pkg::*;
#(
  parameter int unsigned DELAY_TICKS = 45,
  parameter int unsigned MAX_TICKS   = 50,
  parameter int unsigned CW          = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rise_i,
  input  logic          tick_i,
  input  logic          rel_i,
  input  logic [CW-1:0] cnt_i,
  output logic          cnt_clr_o,
  output logic          cnt_inc_o,
  output logic          grant_no,
  output logic          cut_o
);
  win_state_e state_q, state_d;
  logic cut_d, dly_hit, lim_hit;

  assign dly_hit = tick_i && (cnt_i == CW'(DELAY_TICKS - 1));
  assign lim_hit = tick_i && (cnt_i == CW'(MAX_TICKS - 1));
  assign cnt_inc_o = tick_i && (state_q != WIN_IDLE);

  always_comb begin
    state_d   = state_q;
    cut_d     = cut_o;
    cnt_clr_o = 1'b0;
    unique case (state_q)
      WIN_IDLE: if (rise_i) begin
        state_d   = WIN_DELAY;
        cnt_clr_o = 1'b1;
      end
      WIN_DELAY: if (dly_hit) begin
        state_d   = WIN_OPEN;
        cnt_clr_o = 1'b1;
        cut_d     = 1'b0;
      end
      WIN_OPEN: begin
        if (rel_i) begin
          state_d = WIN_IDLE;
          cut_d   = 1'b0;
        end else if (lim_hit) begin
          state_d = WIN_IDLE;
          cut_d   = 1'b1;
        end
      end
      default: state_d = WIN_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= WIN_IDLE;
      grant_no <= 1'b1;
      cut_o    <= 1'b0;
    end else begin
      state_q  <= state_d;
      grant_no <= (state_d != WIN_OPEN);
      cut_o    <= cut_d;
    end
  end

  // R2
  open_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(grant_no) |-> $past(state_q) == WIN_DELAY);
  // R3
  win_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == WIN_OPEN) |-> (cnt_i < CW'(MAX_TICKS)));
  // R3
  limit_close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == WIN_OPEN && lim_hit && !rel_i) |=> grant_no && cut_o);
  // R5
  edge_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == WIN_DELAY && rise_i && !dly_hit) |=> state_q == WIN_DELAY);
  // R4
  cut_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !grant_no |-> !cut_o);
  // R6
  rel_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == WIN_DELAY && rel_i && !dly_hit) |=> state_q == WIN_DELAY);
endmodule

// File: rtl/mbx_strobe_gate.sv
module mbx_strobe_gate #(
  parameter int unsigned NUM_STB = 4
) (
  input  logic               en_i,
  input  logic [NUM_STB-1:0] strb_i,
  output logic [NUM_STB-1:0] oe_o,
  output logic [NUM_STB-1:0] strb_o
);
  for (genvar g = 0; g < NUM_STB; g++) begin : g_lane
    assign oe_o[g]   = en_i;
    assign strb_o[g] = en_i ? strb_i[g] : 1'b1;
  end
endmodule

// File: rtl/mbx_window_gen.sv
module mbx_window_gen
  import mbx_win_pkg::*;
#(
  parameter int unsigned DELAY_TICKS = 45,
  parameter int unsigned MAX_TICKS   = 50,
  parameter int unsigned NUM_STB     = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ref_i,
  input  logic               tick_i,
  input  logic               rel_i,
  input  logic [NUM_STB-1:0] strb_i,
  output logic               grant_no,
  output logic               strb_en_o,
  output logic [NUM_STB-1:0] strb_oe_o,
  output logic [NUM_STB-1:0] strb_o,
  output logic               cut_o
);
  localparam int unsigned CW = $clog2(max_u(DELAY_TICKS, MAX_TICKS) + 1);

  logic          rise, cnt_clr, cnt_inc;
  logic [CW-1:0] cnt;

  mbx_ref_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(ref_i), .rise_o(rise)
  );

  mbx_tick_cnt #(.CW(CW)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(cnt_clr), .inc_i(cnt_inc), .cnt_o(cnt)
  );

  mbx_win_fsm #(.DELAY_TICKS(DELAY_TICKS), .MAX_TICKS(MAX_TICKS), .CW(CW)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .rise_i(rise), .tick_i(tick_i), .rel_i(rel_i),
    .cnt_i(cnt), .cnt_clr_o(cnt_clr), .cnt_inc_o(cnt_inc),
    .grant_no(grant_no), .cut_o(cut_o)
  );

  assign strb_en_o = ~grant_no;

  mbx_strobe_gate #(.NUM_STB(NUM_STB)) u_gate (
    .en_i(strb_en_o), .strb_i(strb_i), .oe_o(strb_oe_o), .strb_o(strb_o)
  );

  // R7
  oe_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_no ? (strb_oe_o == '0) : (&strb_oe_o));
  // R8
  idle_strb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_no |-> (&strb_o));
endmodule

// File: tb/sim_mbx_window_gen.sv
module sim_mbx_window_gen;
  localparam int DLY  = 45;
  localparam int MAXT = 50;
  localparam int NS   = 4;

  logic clk = 1'b0, rst_ni = 1'b0, ref_i = 1'b0, tick_i = 1'b0, rel_i = 1'b0;
  logic [NS-1:0] strb_i = '1;
  logic grant_no, strb_en_o, cut_o;
  logic [NS-1:0] strb_oe_o, strb_o;

  mbx_window_gen #(.DELAY_TICKS(DLY), .MAX_TICKS(MAXT), .NUM_STB(NS)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .ref_i(ref_i), .tick_i(tick_i), .rel_i(rel_i),
    .strb_i(strb_i), .grant_no(grant_no), .strb_en_o(strb_en_o),
    .strb_oe_o(strb_oe_o), .strb_o(strb_o), .cut_o(cut_o)
  );

  always #4 clk = ~clk;

  typedef struct { int dly; int len; bit cut; } exp_t;
  exp_t q[$];
  int checks = 0, fails = 0, nwin = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_sample;
    @(posedge clk); #1;
  endtask

  task automatic wait_tick;
    do wait_sample; while (!tick_i);
  endtask

  // tick every 10 cycles
  initial begin
    @(posedge rst_ni);
    forever begin
      @(negedge clk) tick_i = 1'b1;
      @(negedge clk) tick_i = 1'b0;
      repeat (8) @(negedge clk);
    end
  end

  initial forever begin
    @(negedge clk) strb_i = NS'($urandom);
  end

  // driver: rel_after < 0 lets the limit close the window
  task automatic run_window(int rel_after, bit noise);
    exp_t e;
    e.dly = DLY;
    e.len = (rel_after < 0) ? MAXT : rel_after;
    e.cut = (rel_after < 0);
    q.push_back(e);
    wait_tick;
    @(negedge clk) ref_i = 1'b1;
    if (noise) begin
      repeat (5) wait_tick;
      @(negedge clk) rel_i = 1'b1;   // R6 ignored during delay
      @(negedge clk) begin rel_i = 1'b0; ref_i = 1'b0; end
      repeat (3) @(negedge clk);
      ref_i = 1'b1;                  // R5 edge during delay
    end
    do wait_sample; while (grant_no);
    if (noise) begin
      @(negedge clk) ref_i = 1'b0;
      repeat (3) @(negedge clk);
      ref_i = 1'b1;                  // R5 edge during open window
    end
    if (rel_after >= 0) begin
      repeat (rel_after) wait_tick;
      @(negedge clk) rel_i = 1'b1;
      @(negedge clk) rel_i = 1'b0;
    end
    do wait_sample; while (!grant_no);
    @(negedge clk) ref_i = 1'b0;
    repeat (20) @(negedge clk);
  endtask

  // monitor / scoreboard
  initial begin
    int phase = 0, tcnt = 0;
    logic ref_prev = 1'b0;
    @(posedge rst_ni);
    forever begin
      wait_sample;
      if (!grant_no) begin
        chk(strb_en_o && (strb_oe_o == '1), "R7 enables in window", int'(strb_oe_o), (1 << NS) - 1);
        chk(strb_o == strb_i, "R8 strobe pass", int'(strb_o), int'(strb_i));
      end else begin
        chk(!strb_en_o && (strb_oe_o == '0), "R7 enables outside window", int'(strb_oe_o), 0);
        chk(strb_o == '1, "R8 strobe idle", int'(strb_o), (1 << NS) - 1);
      end
      case (phase)
        0: begin
          chk(grant_no, "R5 no spurious window", int'(grant_no), 1);
          if (ref_i && !ref_prev) begin phase = 1; tcnt = 0; end
        end
        1: begin
          if (tick_i) tcnt++;
          if (!grant_no) begin
            if (q.size() == 0) chk(1'b0, "R5 unexpected window", 1, 0);
            else chk(tcnt == q[0].dly, "R2 delay ticks", tcnt, q[0].dly);
            chk(!cut_o, "R4 cut cleared on open", int'(cut_o), 0);
            phase = 2; tcnt = 0;
          end
        end
        default: begin
          if (tick_i) tcnt++;
          if (grant_no) begin
            if (q.size() != 0) begin
              chk(tcnt == q[0].len, "R3 window length", tcnt, q[0].len);
              chk(cut_o == q[0].cut, "R4 cut flag", int'(cut_o), int'(q[0].cut));
              void'(q.pop_front());
            end
            nwin++;
            phase = 0;
          end
        end
      endcase
      ref_prev = ref_i;
    end
  end

  initial begin
    #20;
    chk(grant_no == 1'b1, "R1 grant reset", int'(grant_no), 1);
    chk(strb_oe_o == '0, "R1 oe reset", int'(strb_oe_o), 0);
    chk(strb_en_o == 1'b0, "R1 en reset", int'(strb_en_o), 0);
    chk(cut_o == 1'b0, "R1 cut reset", int'(cut_o), 0);
    @(negedge clk) rst_ni = 1'b1;
    repeat (30) @(negedge clk);
    @(negedge clk) rel_i = 1'b1;   // R6 ignored when idle
    @(negedge clk) rel_i = 1'b0;
    run_window(-1, 1'b0);          // limit close
    chk(cut_o, "R4 cut held after limit", int'(cut_o), 1);
    run_window(10, 1'b0);          // release close
    chk(!cut_o, "R4 cut held after release", int'(cut_o), 0);
    run_window(-1, 1'b1);          // R5 R6 noise
    run_window(1, 1'b0);
    run_window(0, 1'b0);           // release at once
    repeat (300) @(negedge clk);
    chk(q.size() == 0, "R5 all windows seen", q.size(), 0);
    chk(nwin == 5, "R5 window count", nwin, 5);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", nwin, 5);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule